// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the host-side serial master for a converter that uses the serial clock itself as its conversion clock and converts one sample at a time. A client asks for a conversion with a single-cycle start request. With the request it supplies an 8-bit command byte, a flag that chooses a temperature reading over a voltage reading, and a flag that asks for a reference power-up pause. The sequencer then drives chip select, the serial clock and the serial data line toward the converter, and samples the converter's data output. When the frame ends it presents the 16-bit word it captured, with a one-cycle valid strobe and the measurement type.

A voltage frame is the command byte followed by sixteen read clocks. A temperature frame is the command byte followed by 192 clocks of zeros, and the result is taken from the last sixteen of those clocks. When the pause is requested, chip select is released for a timed window after the eighth clock and then lowered again. That window is set by a system-clock count parameter, which the design checks during elaboration against an upper limit. While the continuous input is held, back-to-back voltage conversions overlap: the next command byte goes out during the second read byte of the current conversion, so each further conversion costs sixteen clocks.

Top module: `adc_conv_seq`

## Requirements
- R1: After reset, chip select is high (inactive), the serial clock is low, and busy and result valid are low.
- R2: A frame starts by pulling chip select low and sending the command byte MSB first over the first 8 serial clocks. The data line changes only at a falling edge of the serial clock (or at frame start) and stays stable while the clock is high. The converter's output is sampled at each rising edge.
- R3: A voltage frame has exactly 24 rising clock edges: 8 for the command, then 16 with the data line held at 0. The result word is the 16 bits sampled on those 16 edges, first sample in bit 15. It is marked as a voltage result (type output 0).
- R4: A temperature frame has exactly 200 rising edges: 8 for the command, then 192 with the data line at 0. The result word is the bits sampled on the final 16 edges, first of those in bit 15. It is marked as a temperature result (type output 1).
- R5: When the pause is requested, chip select goes high right after the falling edge that ends the 8th clock. It stays high for exactly REF_WAIT_CYC system clocks and then goes low again, and clocking resumes. Without the request, chip select never goes high inside a frame. The serial clock is low whenever chip select is high.
- R6: Chip select is never high inside a frame for GAP_LIMIT_CYC system clocks or more. Elaboration rejects a REF_WAIT_CYC that is not below GAP_LIMIT_CYC.
- R7: When the continuous input is high at the falling edge ending clock 16 of a voltage conversion, the current command input goes out on clocks 17 to 24. The next conversion's 16 read clocks follow without releasing chip select. Results then arrive every 16 clocks, and the chain ends with the first conversion for which the input was low at that point.
- R8: Busy rises the cycle after an accepted start and falls in the cycle where the final result valid is high. A start request while busy is ignored.
- R9: Each serial clock phase, high and low, lasts HALF_CYC system clocks, so consecutive rising edges inside a frame are 2*HALF_CYC system clocks apart.
- R10: Result valid is high for one cycle per conversion and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a conversion (accepted when idle) |
| cmd_i | input | CMD_W | Command byte to send |
| temp_i | input | 1 | 1 = temperature frame, 0 = voltage frame |
| refwait_i | input | 1 | Insert the reference power-up pause after the command byte |
| cont_i | input | 1 | Chain further voltage conversions while high |
| busy_o | output | 1 | Sequencer active |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | RES_W | Captured result word |
| res_temp_o | output | 1 | Result is a temperature reading |
| cs_n_o | output | 1 | Chip select to the converter, active low |
| sclk_o | output | 1 | Serial clock, idles low |
| din_o | output | 1 | Serial data to the converter |
| dout_i | input | 1 | Serial data from the converter |

## Verification
The hardest situation to reach from the ports is a continuous chain whose command input changes between conversions and whose continuous input drops partway through. Only the sampling point at clock 16 of each conversion decides what goes out next and when the chain ends. The bench steps the command input just after each result strobe and drops the continuous input after a chosen strobe. It then checks the total clock count, the 16-clock spacing of the strobes and the exact data-line pattern of every command slot. A behavioural converter model feeds a pseudo-random bit stream that changes on falling edges, so a capture that is one bit early or late shows up in the result word. Every one of the 256 command values is swept through voltage frames.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

   // Sequencer phases: idle, clock low, clock high, chip-select pause
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2,
      ST_GAP  = 2'd3
   } seq_state_t;

   // Frame options latched at start
   typedef struct packed {
      logic temp;
      logic pause;
   } frame_opt_t;

endpackage

// File: rtl/adc_seq_tick.sv
`timescale 1ns/1ps
// Half-period pacing: one tick every HALF_CYC cycles while run is high.
module adc_seq_tick #(
   parameter int HALF_CYC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HALF_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run || cnt_q == CNT_TOP) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick = run && (cnt_q == CNT_TOP);

endmodule

// File: rtl/adc_seq_shift.sv
`timescale 1ns/1ps
// Transmit and receive shift registers, MSB first.
module adc_seq_shift #(
   parameter int CMD_W = 8,
   parameter int RES_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_load,
   input  logic [CMD_W-1:0] tx_val,
   input  logic             tx_shift,
   input  logic             rx_sample,
   input  logic             sdi,
   output logic             sdo,
   output logic [RES_W-1:0] rx_word
);
   logic [CMD_W-1:0] tx_q;
   logic [RES_W-1:0] rx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q <= '0;
      end else if (tx_load) begin
         tx_q <= tx_val;
      end else if (tx_shift) begin
         tx_q <= {tx_q[CMD_W-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q <= '0;
      end else if (rx_sample) begin
         rx_q <= {rx_q[RES_W-2:0], sdi};
      end
   end

   assign sdo     = tx_q[CMD_W-1];
   assign rx_word = rx_q;

endmodule

// File: rtl/adc_seq_ctrl.sv
`timescale 1ns/1ps
// Frame sequencing: clock phases, frame length, pause, chaining.
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int CMD_W        = 8,
   parameter int VOLT_READ    = 16,
   parameter int TEMP_READ    = 192,
   parameter int REF_WAIT_CYC = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic temp_req,
   input  logic pause_req,
   input  logic cont_req,
   input  logic tick,
   output logic cs_n,
   output logic sclk,
   output logic run,
   output logic tx_load,
   output logic tx_shift,
   output logic rx_sample,
   output logic take,
   output logic busy,
   output logic frame_temp
);
   localparam int POS_W = $clog2(CMD_W + TEMP_READ + 1);
   localparam int GAP_W = (REF_WAIT_CYC > 1) ? $clog2(REF_WAIT_CYC) : 1;
   localparam logic [POS_W-1:0] POS_CMD   = POS_W'(CMD_W);
   localparam logic [POS_W-1:0] POS_OVL   = POS_W'(VOLT_READ);
   localparam logic [POS_W-1:0] POS_VEND  = POS_W'(CMD_W + VOLT_READ);
   localparam logic [POS_W-1:0] POS_TEND  = POS_W'(CMD_W + TEMP_READ);
   localparam logic [GAP_W-1:0] GAP_TOP   = GAP_W'(REF_WAIT_CYC - 1);

   seq_state_t       state_q;
   frame_opt_t       opt_q;
   logic [POS_W-1:0] pos_q;
   logic [GAP_W-1:0] gap_q;
   logic             chain_q;
   logic             cs_n_q;
   logic             sclk_q;

   logic [POS_W-1:0] pos_nx;
   logic [POS_W-1:0] end_pos;
   logic             rise_ev;
   logic             fall_ev;
   logic             end_ev;
   logic             gap_ev;
   logic             ovl_ev;
   logic             accept;

   always_comb begin
      pos_nx  = pos_q + 1'b1;
      end_pos = opt_q.temp ? POS_TEND : POS_VEND;
      accept  = (state_q == ST_IDLE) && start;
      rise_ev = (state_q == ST_LOW)  && tick;
      fall_ev = (state_q == ST_HIGH) && tick;
      end_ev  = fall_ev && (pos_nx == end_pos);
      gap_ev  = fall_ev && opt_q.pause && (pos_nx == POS_CMD);
      ovl_ev  = fall_ev && !opt_q.temp && cont_req && (pos_nx == POS_OVL);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         opt_q   <= '0;
         pos_q   <= '0;
         gap_q   <= '0;
         chain_q <= 1'b0;
         cs_n_q  <= 1'b1;
         sclk_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  state_q    <= ST_LOW;
                  cs_n_q     <= 1'b0;
                  pos_q      <= '0;
                  chain_q    <= 1'b0;
                  opt_q.temp  <= temp_req;
                  opt_q.pause <= pause_req;
               end
            end
            ST_LOW: begin
               if (tick) begin
                  sclk_q  <= 1'b1;
                  state_q <= ST_HIGH;
               end
            end
            ST_HIGH: begin
               if (tick) begin
                  sclk_q <= 1'b0;
                  pos_q  <= pos_nx;
                  if (ovl_ev) begin
                     chain_q <= 1'b1;
                  end
                  if (end_ev) begin
                     if (chain_q) begin
                        pos_q       <= POS_CMD;
                        chain_q     <= 1'b0;
                        opt_q.pause <= 1'b0;
                        state_q     <= ST_LOW;
                     end else begin
                        cs_n_q  <= 1'b1;
                        state_q <= ST_IDLE;
                     end
                  end else if (gap_ev) begin
                     cs_n_q  <= 1'b1;
                     gap_q   <= '0;
                     state_q <= ST_GAP;
                  end else begin
                     state_q <= ST_LOW;
                  end
               end
            end
            ST_GAP: begin
               if (gap_q == GAP_TOP) begin
                  cs_n_q  <= 1'b0;
                  state_q <= ST_LOW;
               end else begin
                  gap_q <= gap_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cs_n       = cs_n_q;
   assign sclk       = sclk_q;
   assign run        = (state_q == ST_LOW) || (state_q == ST_HIGH);
   assign tx_load    = accept || ovl_ev;
   assign tx_shift   = fall_ev;
   assign rx_sample  = rise_ev;
   assign take       = end_ev;
   assign busy       = (state_q != ST_IDLE);
   assign frame_temp = opt_q.temp;

endmodule

// File: rtl/adc_conv_seq.sv
`timescale 1ns/1ps
// Serial ADC conversion sequencer, top level.
module adc_conv_seq #(
   parameter int HALF_CYC      = 2,
   parameter int CMD_W         = 8,
   parameter int RES_W         = 16,
   parameter int VOLT_READ     = 16,
   parameter int TEMP_READ     = 192,
   parameter int REF_WAIT_CYC  = 40,
   parameter int GAP_LIMIT_CYC = 60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CMD_W-1:0] cmd_i,
   input  logic             temp_i,
   input  logic             refwait_i,
   input  logic             cont_i,
   output logic             busy_o,
   output logic             res_valid_o,
   output logic [RES_W-1:0] res_data_o,
   output logic             res_temp_o,
   output logic             cs_n_o,
   output logic             sclk_o,
   output logic             din_o,
   input  logic             dout_i
);
   // Elaboration-time parameter checks
   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC must be at least 1");
      end
      if (CMD_W < 2) begin : g_bad_cmd
         $error("CMD_W must be at least 2");
      end
      if (VOLT_READ <= CMD_W) begin : g_bad_volt
         $error("VOLT_READ must exceed CMD_W for chained frames");
      end
      if (RES_W < 2 || RES_W > VOLT_READ || RES_W > TEMP_READ) begin : g_bad_res
         $error("RES_W must fit inside both read windows");
      end
      if (REF_WAIT_CYC < 1 || REF_WAIT_CYC >= GAP_LIMIT_CYC) begin : g_bad_wait
         $error("REF_WAIT_CYC must be positive and below GAP_LIMIT_CYC");
      end
   endgenerate

   logic             tick;
   logic             run;
   logic             tx_load;
   logic             tx_shift;
   logic             rx_sample;
   logic             take;
   logic             frame_temp;
   logic [RES_W-1:0] rx_word;

   adc_seq_tick #(
      .HALF_CYC (HALF_CYC)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   adc_seq_ctrl #(
      .CMD_W        (CMD_W),
      .VOLT_READ    (VOLT_READ),
      .TEMP_READ    (TEMP_READ),
      .REF_WAIT_CYC (REF_WAIT_CYC)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_i),
      .temp_req   (temp_i),
      .pause_req  (refwait_i),
      .cont_req   (cont_i),
      .tick       (tick),
      .cs_n       (cs_n_o),
      .sclk       (sclk_o),
      .run        (run),
      .tx_load    (tx_load),
      .tx_shift   (tx_shift),
      .rx_sample  (rx_sample),
      .take       (take),
      .busy       (busy_o),
      .frame_temp (frame_temp)
   );

   adc_seq_shift #(
      .CMD_W (CMD_W),
      .RES_W (RES_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_load   (tx_load),
      .tx_val    (cmd_i),
      .tx_shift  (tx_shift),
      .rx_sample (rx_sample),
      .sdi       (dout_i),
      .sdo       (din_o),
      .rx_word   (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid_o <= 1'b0;
         res_data_o  <= '0;
         res_temp_o  <= 1'b0;
      end else begin
         res_valid_o <= take;
         if (take) begin
            res_data_o <= rx_word;
            res_temp_o <= frame_temp;
         end
      end
   end

endmodule

// File: rtl/adc_conv_seq_chk.sv
`timescale 1ns/1ps
// Protocol checker attached to the sequencer top.
module adc_conv_seq_chk #(
   parameter int HALF_CYC      = 2,
   parameter int GAP_LIMIT_CYC = 60
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sclk,
   input logic din,
   input logic busy,
   input logic valid
);
   localparam int HI_W  = $clog2(HALF_CYC + 2);
   localparam int GAP_W = $clog2(GAP_LIMIT_CYC + 2);

   logic [HI_W-1:0]  hi_q;
   logic [GAP_W-1:0] csh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         csh_q <= '0;
      end else begin
         if (!sclk) begin
            hi_q <= '0;
         end else if (hi_q != '1) begin
            hi_q <= hi_q + 1'b1;
         end
         if (!(cs_n && busy)) begin
            csh_q <= '0;
         end else if (csh_q != '1) begin
            csh_q <= csh_q + 1'b1;
         end
      end
   end

   // R2: data line holds while the serial clock stays high
   a_r2_din_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(din));

   // R5: no clock activity while chip select is released
   a_r5_sclk_low_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sclk);

   // R6: in-frame chip-select pause stays below the limit
   a_r6_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
      csh_q < GAP_W'(GAP_LIMIT_CYC));

   // R8: chip select inactive whenever the sequencer is idle
   a_r8_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs_n);

   // R9: each high phase lasts exactly HALF_CYC cycles
   a_r9_high_phase: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sclk) |-> (hi_q == HI_W'(HALF_CYC)));

   // R10: result strobe is a single-cycle pulse
   a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);

endmodule

bind adc_conv_seq adc_conv_seq_chk #(
   .HALF_CYC      (HALF_CYC),
   .GAP_LIMIT_CYC (GAP_LIMIT_CYC)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cs_n  (cs_n_o),
   .sclk  (sclk_o),
   .din   (din_o),
   .busy  (busy_o),
   .valid (res_valid_o)
);

// File: tb/test_adc_conv_seq.sv
`timescale 1ns/1ps
module test_adc_conv_seq;
   localparam int HALF = 2;
   localparam int WAITC = 40;
   localparam int LIMITC = 60;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [7:0]  cmd_i = '0;
   logic        temp_i = 1'b0;
   logic        refwait_i = 1'b0;
   logic        cont_i = 1'b0;
   logic        busy_o;
   logic        res_valid_o;
   logic [15:0] res_data_o;
   logic        res_temp_o;
   logic        cs_n_o;
   logic        sclk_o;
   logic        din_o;
   logic        dout_i = 1'b0;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   adc_conv_seq #(
      .HALF_CYC (HALF), .CMD_W (8), .RES_W (16), .VOLT_READ (16),
      .TEMP_READ (192), .REF_WAIT_CYC (WAITC), .GAP_LIMIT_CYC (LIMITC)
   ) i_adc_conv_seq (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .cmd_i (cmd_i),
      .temp_i (temp_i), .refwait_i (refwait_i), .cont_i (cont_i),
      .busy_o (busy_o), .res_valid_o (res_valid_o), .res_data_o (res_data_o),
      .res_temp_o (res_temp_o), .cs_n_o (cs_n_o), .sclk_o (sclk_o),
      .din_o (din_o), .dout_i (dout_i)
   );

   task automatic chk(input bit ok, input string rq, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // Behavioural converter: pseudo-random bits launched on falling edges
   logic [15:0] lfsr = 16'hACE1;
   logic [15:0] hist = '0;
   logic        din_log [256];
   int          rise_cnt = 0;

   always @(negedge sclk_o) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      dout_i <= lfsr[0];
   end

   always @(posedge sclk_o) begin
      if (!cs_n_o) begin
         if (rise_cnt < 256) din_log[rise_cnt] = din_o;
         hist = {hist[14:0], dout_i};
         rise_cnt++;
      end
   end

   // Cycle-level monitors
   int  gap_run = 0, last_gap = 0, gap_seen = 0, gap_rise = 0;
   int  valid_cnt = 0;
   int  vr [16];
   logic vtemp = 1'b0;
   logic prev_v = 1'b0;
   logic prev_s = 1'b0;
   int  cyc = 0, last_rise_cyc = 0, hi_len = 0, bad_per = 0, bad_hi = 0;
   bit  have_rise = 0;

   always @(posedge clk) begin
      cyc++;
      if (busy_o && cs_n_o) begin
         if (gap_run == 0) gap_rise = rise_cnt;
         gap_run++;
         have_rise = 0;
      end else if (gap_run > 0) begin
         last_gap = gap_run;
         gap_seen++;
         gap_run = 0;
      end
      if (sclk_o && !prev_s) begin
         if (have_rise && (cyc - last_rise_cyc) != 2 * HALF) bad_per++;
         last_rise_cyc = cyc;
         have_rise = 1;
         hi_len = 0;
      end
      if (sclk_o) hi_len++;
      if (!sclk_o && prev_s && hi_len != HALF) bad_hi++;
      prev_s = sclk_o;
      if (res_valid_o) begin
         chk(res_data_o == hist, res_temp_o ? "R4" : "R3", "captured word",
             res_data_o, hist);
         chk(!prev_v, "R10", "strobe in consecutive cycles", prev_v, 0);
         vtemp = res_temp_o;
         if (valid_cnt < 16) vr[valid_cnt] = rise_cnt;
         valid_cnt++;
      end
      prev_v = res_valid_o;
   end

   task automatic clear_mon();
      rise_cnt = 0; gap_seen = 0; valid_cnt = 0; last_gap = 0;
      bad_per = 0; bad_hi = 0; have_rise = 0;
      for (int i = 0; i < 256; i++) din_log[i] = 1'b0;
   endtask

   function automatic logic [7:0] cmd_at(input int base);
      logic [7:0] v;
      for (int i = 0; i < 8; i++) v[7-i] = din_log[base + i];
      return v;
   endfunction

   task automatic run_frame(input logic [7:0] c, input logic t, input logic w);
      int exp_r;
      int nz;
      string rq;
      @(negedge clk);
      clear_mon();
      cmd_i = c; temp_i = t; refwait_i = w; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; temp_i = 1'b0; refwait_i = 1'b0; cmd_i = ~c;
      while (valid_cnt == 0) @(negedge clk);
      @(negedge clk);
      rq = t ? "R4" : "R3";
      exp_r = 8 + (t ? 192 : 16);
      chk(rise_cnt == exp_r, rq, "rising edges in frame", rise_cnt, exp_r);
      chk(cmd_at(0) == c, "R2", "command byte on data line", cmd_at(0), c);
      nz = 0;
      for (int i = 8; i < exp_r; i++) if (din_log[i]) nz++;
      chk(nz == 0, rq, "ones on data line after command", nz, 0);
      chk(vtemp == t, rq, "result type flag", vtemp, t);
      chk(bad_per == 0 && bad_hi == 0, "R9", "clock phase errors",
          bad_per + bad_hi, 0);
      if (w) begin
         chk(gap_seen == 1, "R5", "pause count", gap_seen, 1);
         chk(last_gap == WAITC, "R5", "pause length", last_gap, WAITC);
         chk(gap_rise == 8, "R5", "edges before pause", gap_rise, 8);
      end else begin
         chk(gap_seen == 0, "R5", "unexpected chip-select pause", gap_seen, 0);
      end
      chk(!busy_o && cs_n_o && valid_cnt == 1, "R8", "idle after one strobe",
          valid_cnt, 1);
   endtask

   task automatic run_ignore();
      @(negedge clk);
      clear_mon();
      cmd_i = 8'hA5; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (30) @(negedge clk);
      chk(busy_o, "R8", "busy mid-frame", busy_o, 1);
      cmd_i = 8'h3C; temp_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; temp_i = 1'b0;
      while (valid_cnt == 0) @(negedge clk);
      repeat (40) @(negedge clk);
      chk(rise_cnt == 24, "R8", "edges with start while busy", rise_cnt, 24);
      chk(cmd_at(0) == 8'hA5, "R8", "command unchanged", cmd_at(0), 8'hA5);
      chk(valid_cnt == 1 && vtemp == 1'b0, "R8", "strobes after ignored start",
          valid_cnt, 1);
      chk(!busy_o && cs_n_o, "R8", "no second frame", busy_o, 0);
   endtask

   task automatic run_chain();
      localparam int K = 4;
      logic [7:0] cs [K+1];
      int bad;
      for (int k = 0; k <= K; k++) cs[k] = 8'h80 | 8'(k * 37 + 5);
      @(negedge clk);
      clear_mon();
      cont_i = 1'b1; cmd_i = cs[0]; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; cmd_i = cs[1];
      for (int k = 1; k <= K; k++) begin
         while (valid_cnt < k) @(negedge clk);
         if (k < K) cmd_i = cs[k+1];
         else cont_i = 1'b0;
      end
      while (valid_cnt < K + 1) @(negedge clk);
      repeat (40) @(negedge clk);
      chk(valid_cnt == K + 1, "R7", "strobes in chain", valid_cnt, K + 1);
      chk(rise_cnt == 24 + 16 * K, "R7", "edges in chain", rise_cnt, 24 + 16 * K);
      chk(vr[0] == 24, "R7", "edge of first strobe", vr[0], 24);
      bad = 0;
      for (int j = 0; j < K; j++) if (vr[j+1] - vr[j] != 16) bad++;
      chk(bad == 0, "R7", "strobe spacing errors", bad, 0);
      bad = 0;
      for (int g = 0; g < 24 + 16 * K; g++) begin
         logic e;
         e = ((g % 16) < 8 && (g / 16) <= K) ? cs[g/16][7 - (g % 16)] : 1'b0;
         if (din_log[g] != e) bad++;
      end
      chk(bad == 0, "R7", "data line pattern mismatches", bad, 0);
      chk(gap_seen == 0, "R7", "chip-select release inside chain", gap_seen, 0);
      chk(!busy_o, "R8", "busy after chain", busy_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(cs_n_o == 1'b1, "R1", "chip select in reset", cs_n_o, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cs_n_o == 1'b1, "R1", "chip select after reset", cs_n_o, 1);
      chk(sclk_o == 1'b0, "R1", "serial clock after reset", sclk_o, 0);
      chk(busy_o == 1'b0, "R1", "busy after reset", busy_o, 0);
      chk(res_valid_o == 1'b0, "R1", "valid after reset", res_valid_o, 0);
      for (int c = 0; c < 256; c++) run_frame(8'(c), 1'b0, 1'b0);
      run_frame(8'hFF, 1'b1, 1'b0);
      run_frame(8'h81, 1'b1, 1'b0);
      run_frame(8'h00, 1'b1, 1'b0);
      run_frame(8'h96, 1'b0, 1'b1);
      run_frame(8'hC3, 1'b1, 1'b1);
      run_ignore();
      run_chain();
      run_frame(8'h5A, 1'b0, 1'b1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL R8: watchdog expired actual=%0d expected=%0d", 150000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule